// File: doc/BRIEF.md
# Prescaled Line/Cycle Interrupt Timer

An 8-bit up-counting interrupt timer for a game-cartridge style bus. It counts either every CPU cycle or at an approximate video-line rate. Line rate comes from a signed prescaler. The prescaler loses 3 on each CPU cycle and gains 341 each time it reaches zero or goes below, so the counter advances 3 times in every 341 CPU cycles.

The counter counts upward. When it is advanced while holding all ones, it takes the reload value and raises a level interrupt. The interrupt stays high until software writes the control or acknowledge register.

Software drives the timer through a write port with a 2-bit register select:

- the reload register;
- a control register that selects the mode, starts the timer and stores a resume bit;
- an acknowledge register that clears the interrupt and copies the resume bit back into the run bit.

A separate pulse marks each CPU cycle.

Top module: `line_irq_timer`

## Requirements
- R1: After reset `irq_o` is 0, the timer is stopped, the reload value is 0 and the prescaler is 0. Ticks given before any start have no effect, and a later start with the reset reload value raises the interrupt on the 256th tick.
- R2: A write with select 0 stores `wr_data_i` as the reload value. It does not change `irq_o`, and the value is used at the next start or the next wrap.
- R3: A write with select 1 uses three data bits: bit 2 is the mode (1 = per-cycle, 0 = line rate), bit 1 is the run bit and bit 0 is the resume bit. The write clears `irq_o`. If bit 1 is set, the counter loads the reload value and the prescaler loads 341.
- R4: A write with select 2 copies the resume bit into the run bit and clears `irq_o`.
- R5: In per-cycle mode with run set, each tick advances the counter by one. After a start with reload value L, the interrupt rises on tick 256-L.
- R6: In line-rate mode with run set, each tick lowers the prescaler by 3. When the result is 0 or less, 341 is added and the counter advances once. After a start, advances fall on ticks 114, 228 and 341, and the pattern repeats with intervals 114, 114, 113.
- R7: A counter advance at 0xFF reloads the counter and sets `irq_o`. `irq_o` is a level that stays high across later wraps until an R3 or R4 write.
- R8: With the run bit clear, ticks change neither the counter nor the prescaler.
- R9: A tick in a cycle where `wr_en_i` is high is not counted.
- R10: A write with select 3 changes neither `irq_o` nor the timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per CPU cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 reload, 1 control, 2 acknowledge, 3 unused |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so `irq_o` is already clear one cycle after a control or acknowledge write. The wrapping tick also sets `irq_o` at the edge that samples it, so the interrupt is visible one cycle after the tick with no extra pipeline stage. The bench drives every input just after a falling edge and reads `irq_o` at the next falling edge. Each check follows an exact tick count computed from the requirements (256-L ticks, or the 114/114/113 line-rate pattern) and is made on the tick before the expected rise and on the tick of the rise.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RELOAD = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_ACK    = 2'd2,
    SEL_SPARE  = 2'd3
  } sel_e;

  localparam int unsigned CTRL_MODE_BIT   = 2;
  localparam int unsigned CTRL_RUN_BIT    = 1;
  localparam int unsigned CTRL_RESUME_BIT = 0;

  typedef struct packed {
    logic cyc_mode;
    logic run;
    logic resume;
  } ctrl_t;
endpackage

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  sel_e              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] reload_o,
  output ctrl_t             ctrl_o,
  output logic              arm_o,
  output logic              clear_o
);
  logic [DATA_W-1:0] reload_q;
  ctrl_t             ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_i)
        SEL_RELOAD: reload_q <= wr_data_i;
        SEL_CTRL: begin
          ctrl_q.cyc_mode <= wr_data_i[CTRL_MODE_BIT];
          ctrl_q.run      <= wr_data_i[CTRL_RUN_BIT];
          ctrl_q.resume   <= wr_data_i[CTRL_RESUME_BIT];
        end
        SEL_ACK:  ctrl_q.run <= ctrl_q.resume;
        default:  ;
      endcase
    end
  end

  always_comb begin
    arm_o    = wr_en_i && (wr_sel_i == SEL_CTRL) && wr_data_i[CTRL_RUN_BIT];
    clear_o  = wr_en_i && ((wr_sel_i == SEL_CTRL) || (wr_sel_i == SEL_ACK));
    reload_o = reload_q;
    ctrl_o   = ctrl_q;
  end
endmodule

// File: rtl/lit_prescale.sv
module lit_prescale #(
  parameter int unsigned W      = 10,
  parameter int unsigned STEP   = 3,
  parameter int unsigned PERIOD = 341
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                adv_i,
  output logic signed [W-1:0] pre_o,
  output logic                fire_o
);
  localparam logic signed [W-1:0] STEP_S   = W'(STEP);
  localparam logic signed [W-1:0] PERIOD_S = W'(PERIOD);
  localparam logic signed [W-1:0] ZERO_S   = '0;

  logic signed [W-1:0] pre_q;
  logic signed [W-1:0] dec;

  always_comb begin
    dec    = pre_q - STEP_S;
    fire_o = adv_i && (dec <= ZERO_S);
    pre_o  = pre_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (arm_i)   pre_q <= PERIOD_S;
    else if (adv_i)   pre_q <= fire_o ? dec + PERIOD_S : dec;
  end
endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= reload_i;
    else if (step_i)  cnt_q <= wrap_o ? reload_i : cnt_q + 1'b1;
  end
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
  import lit_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PRE_W      = 10,
  parameter int unsigned PRE_STEP   = 3,
  parameter int unsigned PRE_PERIOD = 341
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             irq_o
);
  logic [CNT_W-1:0]        reload_s;
  ctrl_t                   ctrl_s;
  logic                    arm_s;
  logic                    clear_s;
  logic signed [PRE_W-1:0] pre_s;
  logic                    pre_fire_s;
  logic [CNT_W-1:0]        cnt_s;
  logic                    wrap_s;
  logic                    live_s;
  logic                    pre_adv_s;
  logic                    cnt_step_s;
  logic                    irq_q;

  lit_regs #(.DATA_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel_e'(wr_sel_i)),
    .wr_data_i (wr_data_i),
    .reload_o  (reload_s),
    .ctrl_o    (ctrl_s),
    .arm_o     (arm_s),
    .clear_o   (clear_s)
  );

  // a write cycle swallows the tick
  assign live_s     = tick_i && ctrl_s.run && !wr_en_i;
  assign pre_adv_s  = live_s && !ctrl_s.cyc_mode;
  assign cnt_step_s = live_s && (ctrl_s.cyc_mode || pre_fire_s);

  lit_prescale #(.W(PRE_W), .STEP(PRE_STEP), .PERIOD(PRE_PERIOD)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_s),
    .adv_i  (pre_adv_s),
    .pre_o  (pre_s),
    .fire_o (pre_fire_s)
  );

  lit_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (arm_s),
    .step_i   (cnt_step_s),
    .reload_i (reload_s),
    .cnt_o    (cnt_s),
    .wrap_o   (wrap_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (clear_s) irq_q <= 1'b0;
    else if (wrap_s)  irq_q <= 1'b1;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/line_irq_timer_chk.sv
module line_irq_timer_chk #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PRE_W      = 10,
  parameter int unsigned PRE_PERIOD = 341
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    wr_en_i,
  input logic [1:0]              wr_sel_i,
  input logic                    irq_o,
  input logic                    run_i,
  input logic                    mode_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic signed [PRE_W-1:0] pre_i
);
  localparam logic signed [PRE_W-1:0] PERIOD_S = PRE_W'(PRE_PERIOD);
  localparam logic signed [PRE_W-1:0] ZERO_S   = '0;
  localparam logic [CNT_W-1:0]        ONE      = CNT_W'(1);

  p_clr_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1) |=> !irq_o);

  p_clr_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2) |=> !irq_o);

  p_count_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i && tick_i && !wr_en_i && cnt_i != '1) |=> cnt_i == $past(cnt_i) + ONE);

  p_pre_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i >= ZERO_S) && (pre_i <= PERIOD_S));

  p_rise_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(cnt_i) == '1) && $past(tick_i) && !$past(wr_en_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(cnt_i) && $stable(pre_i));

  p_wr_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> $stable(cnt_i) && $stable(pre_i));

  p_spare_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=> $stable(irq_o) && $stable(cnt_i) && $stable(run_i) && $stable(mode_i));
endmodule

bind line_irq_timer line_irq_timer_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_PERIOD(PRE_PERIOD)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .irq_o    (irq_o),
  .run_i    (ctrl_s.run),
  .mode_i   (ctrl_s.cyc_mode),
  .cnt_i    (cnt_s),
  .pre_i    (pre_s)
);

// File: tb/line_irq_timer_bench.sv
`timescale 1ns/1ps
module line_irq_timer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  line_irq_timer u_line_irq_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%0b expected %0b", req, irq, exp);
    end
  endtask

  // drive after a falling edge, return at the next falling edge
  task automatic cyc(input logic t, input logic we, input logic [1:0] s, input logic [7:0] d);
    tick = t; wr_en = we; wr_sel = s; wr_data = d;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    cyc(1'b0, 1'b1, s, d);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 irq low in reset", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 irq low after reset", 1'b0);
    ticks(300);
    chk("R1 no count before start", 1'b0);
    wr(2'd1, 8'h06);
    ticks(255);
    chk("R1 reload zero, tick 255", 1'b0);
    ticks(1);
    chk("R1 reload zero, tick 256", 1'b1);
    wr(2'd1, 8'h00);
    chk("R3 control write clears", 1'b0);
  endtask

  task automatic t_cycle;
    wr(2'd0, 8'hFC);
    wr(2'd1, 8'h06);
    ticks(3);
    chk("R5 tick 3 of 4", 1'b0);
    ticks(1);
    chk("R5 tick 4 of 4", 1'b1);
    wr(2'd0, 8'h10);
    chk("R2 reload write keeps irq", 1'b1);
    ticks(4);
    chk("R7 level held over wrap", 1'b1);
    wr(2'd1, 8'h06);
    chk("R3 restart clears irq", 1'b0);
    ticks(239);
    chk("R2 new reload, tick 239", 1'b0);
    ticks(1);
    chk("R2 new reload, tick 240", 1'b1);
  endtask

  task automatic t_line;
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h03);
    ticks(113);
    chk("R6 first interval tick 113", 1'b0);
    ticks(1);
    chk("R6 first interval tick 114", 1'b1);
    wr(2'd2, 8'h00);
    chk("R4 ack clears irq", 1'b0);
    ticks(113);
    chk("R6 second interval tick 113", 1'b0);
    ticks(1);
    chk("R6 second interval tick 114", 1'b1);
    wr(2'd2, 8'h00);
    ticks(112);
    chk("R6 third interval tick 112", 1'b0);
    ticks(1);
    chk("R6 third interval tick 113", 1'b1);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h02);
    ticks(227);
    chk("R6 two advances tick 227", 1'b0);
    ticks(1);
    chk("R6 two advances tick 228", 1'b1);
    wr(2'd0, 8'hFD);
    wr(2'd1, 8'h02);
    ticks(340);
    chk("R6 three advances tick 340", 1'b0);
    ticks(1);
    chk("R6 three advances tick 341", 1'b1);
  endtask

  task automatic t_ack_stop;
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h06);
    ticks(2);
    chk("R5 reload FE tick 2", 1'b1);
    wr(2'd2, 8'h00);
    chk("R4 ack clears", 1'b0);
    ticks(300);
    chk("R4 resume 0 stops timer", 1'b0);
  endtask

  task automatic t_hold;
    wr(2'd0, 8'hFC);
    wr(2'd1, 8'h07);
    ticks(2);
    wr(2'd1, 8'h05);
    chk("R8 stop write clears", 1'b0);
    ticks(50);
    chk("R8 stopped ticks ignored", 1'b0);
    wr(2'd2, 8'h00);
    ticks(1);
    chk("R8 counter held at FE", 1'b0);
    ticks(1);
    chk("R8 counter held, wrap", 1'b1);
  endtask

  task automatic t_block;
    wr(2'd0, 8'hFC);
    wr(2'd1, 8'h07);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 2'd0, 8'hFC);
    ticks(3);
    chk("R9 write-cycle ticks not counted", 1'b0);
    ticks(1);
    chk("R9 fourth counted tick wraps", 1'b1);
  endtask

  task automatic t_spare;
    cyc(1'b1, 1'b1, 2'd3, 8'hFF);
    wr(2'd3, 8'h00);
    chk("R10 spare write keeps irq", 1'b1);
    wr(2'd2, 8'h00);
    ticks(3);
    chk("R10 state intact tick 3", 1'b0);
    ticks(1);
    chk("R10 state intact tick 4", 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cycle();
    t_line();
    t_ack_stop();
    t_hold();
    t_block();
    t_spare();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule